// File: doc/BRIEF.md
# Wide-Symbol Reed-Solomon Encoder and Byte Framer

This block sits behind an outer encoder that produces very wide code symbols (102 bits each). It gathers three such symbols, reinterprets the resulting 306 bits as 51 six-bit symbols over GF(64), and appends 12 parity symbols. The parity comes from a systematic (63,51) Reed-Solomon code, so the message passes through unchanged. The 378-bit codeword is padded to a whole number of bytes and sent after a fixed two-byte marker. The output is a byte stream that can feed a serial transmitter directly.

Input symbols arrive on a valid/ready handshake, one 102-bit symbol per beat. Once a group of three is complete, the block stops accepting input. It then computes parity with a linear-feedback shift register that takes one symbol per cycle. After that it streams out the 50-byte frame on a byte-wide valid/ready port, and only then returns to accepting input.

Top module: `rsfr_enc_framer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Three accepted input symbols form one message. Bits are packed most significant first: bit 101 of the first symbol becomes bit 5 (the top bit) of message symbol 0. The 306 message bits appear unchanged, in arrival order, as the first 306 codeword bits of the frame.
- R3: Every frame starts with byte 0x7E followed by byte 0x7F.
- R4: The field is built from x^6+x+1 with alpha = 6'b000010. Message symbol 0 is the coefficient of x^62 and the last parity symbol is the coefficient of x^0. The 63-symbol codeword polynomial is zero at alpha^1 through alpha^12. An all-zero message gives all-zero parity.
- R5: A frame is exactly 50 bytes, each sent most significant bit first. Bytes 2 to 49 carry the 378 codeword bits followed by 6 zero bits.
- R6: `in_ready` is 0 from the cycle after the third symbol of a group is accepted until the last byte of its frame is accepted. It is never 1 while `out_valid` is 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_byte` holds its value.
- R8: A group with fewer than three accepted symbols produces no output. The held symbols are kept until the group completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can accept an input symbol |
| in_sym | input | 102 | Wide outer-code symbol |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Frame byte, marker first |

## Verification
Parity is judged by evaluating the received codeword at the twelve roots rather than by re-running an encoder. A wrong generator coefficient, a wrong field polynomial or a parity register taken in the wrong order therefore leaves a non-zero syndrome. Vectors with a single set top bit and with alternating patterns expose packing that is reversed or shifted by a symbol, because the message bits then land away from the frame's codeword start. Downstream stalls at irregular cycles catch a serializer that advances or drops a byte without a handshake. A group that pauses after two symbols catches a counter that starts encoding early or loses the held symbols.

// File: rtl/rsfr_pkg.sv
package rsfr_pkg;
    localparam int SYM_W       = 6;
    localparam int CW_N        = 63;
    localparam int MSG_K       = 51;
    localparam int PAR_N       = CW_N - MSG_K;
    localparam int IN_W        = 102;
    localparam int GRP         = 3;
    localparam int MSG_BITS    = IN_W * GRP;
    localparam int CW_BITS     = CW_N * SYM_W;
    localparam int PAD_BITS    = (8 - (CW_BITS % 8)) % 8;
    localparam int HDR_BYTES   = 2;
    localparam int FRAME_BITS  = HDR_BYTES * 8 + CW_BITS + PAD_BITS;
    localparam int FRAME_BYTES = FRAME_BITS / 8;
    localparam logic [7:0] MARK_A = 8'h7E;
    localparam logic [7:0] MARK_B = 8'h7F;
    // low-order terms of the primitive polynomial x^6 + x + 1
    localparam logic [SYM_W-1:0] PRIM_TAIL = 6'h03;
    localparam logic [SYM_W-1:0] ALPHA     = 6'h02;

    typedef logic [SYM_W-1:0] sym_t;
    typedef enum logic [1:0] {ST_COLLECT, ST_ENCODE, ST_LOAD, ST_SEND} ctl_st_e;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? PRIM_TAIL : '0);
        end
        return acc;
    endfunction

    // generator polynomial coefficients, g[0] in the low bits, monic top term included
    function automatic logic [(PAR_N+1)*SYM_W-1:0] gen_poly();
        logic [(PAR_N+1)*SYM_W-1:0] g;
        sym_t root;
        g = '0;
        g[0 +: SYM_W] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 1; i <= PAR_N; i++) begin
            root = gf_mul(root, ALPHA);
            for (int j = PAR_N; j > 0; j--) begin
                g[j*SYM_W +: SYM_W] = g[(j-1)*SYM_W +: SYM_W] ^ gf_mul(g[j*SYM_W +: SYM_W], root);
            end
            g[0 +: SYM_W] = gf_mul(g[0 +: SYM_W], root);
        end
        return g;
    endfunction
endpackage

// File: rtl/rsfr_collect.sv
module rsfr_collect
    import rsfr_pkg::*;
#(
    parameter int DW  = IN_W,
    parameter int NG  = GRP,
    parameter int SW  = SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [DW-1:0]    din,
    input  logic             rot,
    output logic             last_slot,
    output logic [SW-1:0]    head_sym,
    output logic [DW*NG-1:0] msg
);
    localparam int MB    = DW * NG;
    localparam int CNT_W = (NG > 1) ? $clog2(NG) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NG - 1);

    typedef struct packed {
        logic [MB-1:0]    msg;
        logic [CNT_W-1:0] cnt;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (take) begin
            col_d.msg = {col_q.msg[MB-DW-1:0], din};
            col_d.cnt = (col_q.cnt == CNT_LAST) ? '0 : col_q.cnt + 1'b1;
        end else if (rot) begin
            col_d.msg = {col_q.msg[MB-SW-1:0], col_q.msg[MB-1 -: SW]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign last_slot = (col_q.cnt == CNT_LAST);
    assign head_sym  = col_q.msg[MB-1 -: SW];
    assign msg       = col_q.msg;

    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.cnt <= CNT_LAST);
    a_r2_take_moves: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (col_q.msg[DW-1:0] == $past(din)));
    a_r8_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !rot) |=> $stable(col_q.msg));
endmodule

// File: rtl/rsfr_parity.sv
module rsfr_parity
    import rsfr_pkg::*;
#(
    parameter int SW = SYM_W,
    parameter int NP = PAR_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [SW-1:0]    sym_in,
    output logic [NP*SW-1:0] par_out
);
    localparam logic [(PAR_N+1)*SYM_W-1:0] GEN_ALL = gen_poly();
    localparam logic [NP*SW-1:0] GEN = GEN_ALL[NP*SW-1:0];

    typedef struct packed {
        logic [NP*SW-1:0] par;
    } par_t;

    par_t par_d, par_q;
    logic [SW-1:0] fb;

    always_comb begin
        par_d = par_q;
        fb    = sym_in ^ par_q.par[NP*SW-1 -: SW];
        if (clr) begin
            par_d.par = '0;
        end else if (step) begin
            par_d.par[0 +: SW] = gf_mul(fb, GEN[0 +: SW]);
            for (int i = 1; i < NP; i++) begin
                par_d.par[i*SW +: SW] = par_q.par[(i-1)*SW +: SW] ^ gf_mul(fb, GEN[i*SW +: SW]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign par_out = par_q.par;

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par_out == '0));
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(par_out));
endmodule

// File: rtl/rsfr_serial.sv
module rsfr_serial
    import rsfr_pkg::*;
#(
    parameter int NB = FRAME_BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NB*8-1:0] frame,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [7:0]      out_byte,
    output logic            done
);
    localparam int LW = $clog2(NB + 1);
    localparam logic [LW-1:0] LEFT_FULL = LW'(NB);

    typedef struct packed {
        logic [NB*8-1:0] sh;
        logic [LW-1:0]   left;
    } ser_t;

    ser_t ser_d, ser_q;
    logic acc;

    always_comb begin
        ser_d = ser_q;
        acc   = (ser_q.left != '0) && out_ready;
        done  = acc && (ser_q.left == LW'(1));
        if (load) begin
            ser_d.sh   = frame;
            ser_d.left = LEFT_FULL;
        end else if (acc) begin
            ser_d.sh   = {ser_q.sh[NB*8-9:0], 8'h00};
            ser_d.left = ser_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign out_valid = (ser_q.left != '0);
    assign out_byte  = ser_q.sh[NB*8-1 -: 8];

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
    a_r5_left_range: assert property (@(posedge clk) disable iff (!rst_n)
        ser_q.left <= LEFT_FULL);
    a_r5_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
endmodule

// File: rtl/rsfr_enc_framer.sv
module rsfr_enc_framer
    import rsfr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IN_W-1:0] in_sym,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_byte
);
    localparam int STEP_W = $clog2(MSG_K);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(MSG_K - 1);

    typedef struct packed {
        ctl_st_e           st;
        logic [STEP_W-1:0] step;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  take;
    logic                  last_slot;
    logic [SYM_W-1:0]      head_sym;
    logic [MSG_BITS-1:0]   msg;
    logic [PAR_N*SYM_W-1:0] par;
    logic                  par_clr;
    logic                  enc_step;
    logic                  ser_load;
    logic                  ser_done;
    logic [FRAME_BITS-1:0] frame;

    assign in_ready = (ctl_q.st == ST_COLLECT);
    assign take     = in_valid && in_ready;
    assign frame    = {MARK_A, MARK_B, msg, par, {PAD_BITS{1'b0}}};

    always_comb begin
        ctl_d    = ctl_q;
        par_clr  = 1'b0;
        enc_step = 1'b0;
        ser_load = 1'b0;
        unique case (ctl_q.st)
            ST_COLLECT: begin
                if (take && last_slot) begin
                    ctl_d.st   = ST_ENCODE;
                    ctl_d.step = '0;
                    par_clr    = 1'b1;
                end
            end
            ST_ENCODE: begin
                enc_step = 1'b1;
                if (ctl_q.step == STEP_LAST) ctl_d.st = ST_LOAD;
                else                         ctl_d.step = ctl_q.step + 1'b1;
            end
            ST_LOAD: begin
                ser_load = 1'b1;
                ctl_d.st = ST_SEND;
            end
            ST_SEND: begin
                if (ser_done) ctl_d.st = ST_COLLECT;
            end
            default: ctl_d.st = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_COLLECT;
            ctl_q.step <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rsfr_collect #(.DW(IN_W), .NG(GRP), .SW(SYM_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .din       (in_sym),
        .rot       (enc_step),
        .last_slot (last_slot),
        .head_sym  (head_sym),
        .msg       (msg)
    );

    rsfr_parity #(.SW(SYM_W), .NP(PAR_N)) u_parity (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (par_clr),
        .step    (enc_step),
        .sym_in  (head_sym),
        .par_out (par)
    );

    rsfr_serial #(.NB(FRAME_BYTES)) u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_load),
        .frame     (frame),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .done      (ser_done)
    );

    a_r6_ready_vs_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r6_block_after_group: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_slot) |=> !in_ready);
    a_r3_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_byte == MARK_A));
    a_r4_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.step <= STEP_LAST);
endmodule

// File: tb/tb_rsfr_enc_framer.sv
module tb_rsfr_enc_framer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [101:0] in_sym = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [7:0] out_byte;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    logic [7:0] rx [50];
    int r6_bad;
    int r7_bad;

    always #2.5 clk = ~clk;

    rsfr_enc_framer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sym(in_sym), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    localparam int NV = 5;
    localparam logic [305:0] VEC [NV] = '{
        306'h0,
        ~306'h0,
        {1'b1, 305'h0},
        {51{6'b101101}},
        {34{9'h1A5}}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input bit ok, input logic [383:0] act, input logic [383:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] fmul(input logic [5:0] a, input logic [5:0] b);
        logic [10:0] p;
        p = '0;
        for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (11'(a) << i);
        for (int k = 10; k >= 6; k--) if (p[k]) p = p ^ (11'(7'b1000011) << (k - 6));
        return p[5:0];
    endfunction

    task automatic send_sym(input logic [101:0] s);
        @(negedge clk);
        in_valid = 1'b1;
        in_sym = s;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic recv_frame(input int bp);
        int got = 0;
        int k = 0;
        bit prev_stall = 0;
        logic [7:0] prev_byte = '0;
        bit rdy;
        r6_bad = 0;
        r7_bad = 0;
        while (got < 50) begin
            @(negedge clk);
            k++;
            if (prev_stall && (!out_valid || out_byte !== prev_byte)) r7_bad++;
            if (out_valid && in_ready) r6_bad++;
            rdy = (bp == 0) ? 1'b1 : ((k % 3) != 0 && (k % 7) != 2);
            out_ready = rdy;
            if (out_valid && rdy) begin
                rx[got] = out_byte;
                got++;
            end
            prev_stall = out_valid && !rdy;
            prev_byte = out_byte;
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic check_frame(input logic [305:0] m, input string tag);
        logic [383:0] bits;
        logic [5:0] c [63];
        logic [5:0] r, s;
        bit synd_ok;
        for (int i = 0; i < 48; i++) bits[383 - 8*i -: 8] = rx[i + 2];
        chk({"R3 header ", tag}, rx[0] == 8'h7E && rx[1] == 8'h7F,
            384'({rx[0], rx[1]}), 384'h7E7F);
        chk({"R2 message ", tag}, bits[383:78] == m, 384'(bits[383:78]), 384'(m));
        chk({"R5 pad ", tag}, bits[5:0] == 6'h0, 384'(bits[5:0]), 384'h0);
        for (int i = 0; i < 63; i++) c[i] = bits[383 - 6*i -: 6];
        synd_ok = 1;
        r = 6'h01;
        for (int j = 1; j <= 12; j++) begin
            r = fmul(r, 6'h02);
            s = '0;
            for (int i = 0; i < 63; i++) s = fmul(s, r) ^ c[i];
            if (s != 0) synd_ok = 0;
        end
        chk({"R4 syndromes ", tag}, synd_ok, 384'(bits[77:6]), 384'h0);
        if (m == '0) chk({"R4 zero parity ", tag}, bits[77:6] == '0, 384'(bits[77:6]), 384'h0);
        chk({"R6 ready low while sending ", tag}, r6_bad == 0, 384'(r6_bad), 384'h0);
        chk({"R7 hold under stall ", tag}, r7_bad == 0, 384'(r7_bad), 384'h0);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        chk("R1 in_ready after reset", in_ready == 1'b1, 384'(in_ready), 384'h1);
        chk("R1 out_valid after reset", out_valid == 1'b0, 384'(out_valid), 384'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            send_sym(VEC[v][305:204]);
            send_sym(VEC[v][203:102]);
            send_sym(VEC[v][101:0]);
            @(negedge clk);
            chk($sformatf("R6 blocked after group v%0d", v), in_ready == 1'b0, 384'(in_ready), 384'h0);
            recv_frame(v % 2);
            check_frame(VEC[v], $sformatf("v%0d", v));
            chk($sformatf("R6 ready restored v%0d", v), in_ready == 1'b1, 384'(in_ready), 384'h1);
        end

        // R8: two symbols then a long pause
        send_sym(VEC[3][305:204]);
        send_sym(VEC[3][203:102]);
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        chk("R8 partial group silent", seen == 0, 384'(seen), 384'h0);
        chk("R8 still accepting", in_ready == 1'b1, 384'(in_ready), 384'h1);
        send_sym(VEC[3][101:0]);
        recv_frame(1);
        check_frame(VEC[3], "R8 completed");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule